// File: doc/BRIEF.md
# Half-Exponent Signed-Digit Modular Exponentiation Sequencer

This block raises a base to a signed-digit exponent modulo a small prime. The host pulses `start` with the base, the modulus and the digit count. It then feeds the exponent one digit per cycle, least significant digit first. Internally the digit string is cut into a low half and a high half of equal length. If the count is odd, a zero digit is added at the top.

The block walks both halves in step, from position 0 upward. At each step the pair made of the high-half digit and the low-half digit picks one of eight accumulators, one for every pair except (0,0). The selected accumulator is multiplied by a running power of the base, and that power is then squared.

When the walk ends, a fixed program combines the accumulators:
- The negative partial products of each half are inverted by raising them to `p-2`.
- The high half's result is squared once per half-length.
- The low and high results are multiplied to give the answer.

A single bit-serial modular multiplier does every product. The block therefore has no divider.

Top module: `hx_expo`

## Requirements
- R1: After reset, `done` and `err` are 0 and `y` is 0.
- R2: After a `start` pulse in idle, the block captures `len` digits on cycles where `dig_vld` is 1, least significant first. Digit codes are 2'b00 = 0, 2'b01 = +1 and 2'b11 = -1. It then pulses `done` with `err` = 0 and `y` = x^e mod p, where e = sum of d_j * 2^j. A negative e means the modular inverse of x raised to |e|. This assumes p is an odd prime, 0 < x < p, and len <= MAXD.
- R3: An odd digit count gives the same `y` as that count plus one explicit leading zero digit.
- R4: A digit count of zero gives `y` = 1.
- R5: A captured digit 2'b10 ends the job at once: the next cycle shows `done` = 1, `err` = 1 and `y` = 0. `err` stays set until the next accepted `start`, and a later valid job reports `err` = 0.
- R6: `done` is high for exactly one cycle per job. `y` changes only in a cycle where `done` is high and otherwise holds its value.
- R7: `start` is ignored while a job is running, and the running job's result is unaffected.
- R8: Every product from the internal multiplier is below the modulus, including when x = p-1 with a 16-bit modulus.
- R9: `dig_in` is ignored in cycles where `dig_vld` is 0, including the illegal code 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a job when idle; base, modulus and count are sampled here |
| x | input | W | Base, nonzero and below the modulus |
| modulus | input | W | Odd prime modulus |
| len | input | CW | Number of exponent digits, 0 to MAXD |
| dig_vld | input | 1 | Qualifies `dig_in` |
| dig_in | input | 2 | One signed exponent digit |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal digit seen in the last job |
| y | output | W | Result, held between completions |

## Verification
The result has no fixed latency. Each product costs about W+3 cycles from issue to write-back. The count of products depends on the digit pattern, on the bits of p-2 and on the half-length, so `done` is the only timing reference for `y` and `err`. The bench therefore waits on `done` with a per-job cycle limit. It samples `y` and `err` on the falling edge of the cycle where `done` is high. It then checks that `done` has dropped one cycle later and that `y` still holds its value several cycles after that.

// File: rtl/hx_expo.sv
module hx_expo #(
  parameter int W    = 16,
  parameter int MAXD = 32,
  localparam int CW  = $clog2(MAXD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  x,
  input  logic [W-1:0]  modulus,
  input  logic [CW-1:0] len,
  input  logic          dig_vld,
  input  logic [1:0]    dig_in,
  output logic          done,
  output logic          err,
  output logic [W-1:0]  y
);

  localparam int WB  = $clog2(W);
  localparam int DIW = $clog2(2 * MAXD);
  localparam int NR  = 12;
  localparam logic [3:0] RS = 4'd8, RT = 4'd9, RL = 4'd10, RE = 4'd11;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_STEP, S_SQ, S_POST} st_t;

  st_t               st;
  logic [W-1:0]      rf [0:NR-1];
  logic [W-1:0]      p_r;
  logic [2*MAXD-1:0] dbuf;
  logic [CW-1:0]     lenq, cnt, half, si, hc;
  logic [3:0]        pc;
  logic [1:0]        sub;
  logic [WB-1:0]     ib;
  logic              pend;

  logic              mgo, mbusy, mdone;
  logic [W-1:0]      ma, mb, macc;
  logic [WB-1:0]     mcnt;
  logic [W:0]        dbl, r1, sum, r2;

  logic [1:0]        d_lo, d_hi;
  logic [3:0]        code, pidx;
  logic              pair_nz;
  logic [W-1:0]      pm2;
  logic              want, fire;
  logic [3:0]        sa, sb, dst;

  function automatic logic [3:0] tri3(input logic [1:0] d);
    return (d == 2'b11) ? 4'd0 : (d == 2'b01) ? 4'd2 : 4'd1;
  endfunction

  assign half    = (lenq + CW'(1)) >> 1;
  assign d_lo    = dbuf[DIW'({si, 1'b0}) +: 2];
  assign d_hi    = dbuf[DIW'({half + si, 1'b0}) +: 2];
  assign code    = tri3(d_hi) * 4'd3 + tri3(d_lo);
  assign pair_nz = code != 4'd4;
  assign pidx    = (code > 4'd4) ? code - 4'd1 : code;
  assign pm2     = p_r - W'(2);

  assign dbl = {macc, 1'b0};
  assign r1  = (dbl >= {1'b0, p_r}) ? dbl - {1'b0, p_r} : dbl;
  assign sum = r1 + {1'b0, (mb[mcnt] ? ma : '0)};
  assign r2  = (sum >= {1'b0, p_r}) ? sum - {1'b0, p_r} : sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mbusy <= 1'b0;
      mdone <= 1'b0;
      mcnt  <= '0;
      macc  <= '0;
    end else begin
      mdone <= mbusy && (mcnt == '0) && !mgo;
      if (mgo) begin
        mbusy <= 1'b1;
        mcnt  <= WB'(W - 1);
        macc  <= '0;
      end else if (mbusy) begin
        macc <= W'(r2);
        if (mcnt == '0) mbusy <= 1'b0;
        else            mcnt  <= mcnt - WB'(1);
      end
    end
  end

  always_comb begin
    want = 1'b0;
    sa   = RT;
    sb   = RT;
    dst  = RT;
    case (st)
      S_STEP: begin
        want = pair_nz;
        sa   = pidx;
        sb   = RS;
        dst  = pidx;
      end
      S_SQ: begin
        want = 1'b1;
        sa   = RS;
        sb   = RS;
        dst  = RS;
      end
      S_POST: begin
        case (pc)
          4'd0:  begin want = 1'b1; sa = 4'd3; sb = 4'd5; end
          4'd1:  begin want = 1'b1; sb = 4'd0; end
          4'd2, 4'd8: begin
            if (sub == 2'd1) begin
              want = pm2[ib];
              sb   = RE;
            end else if (sub == 2'd2) begin
              want = 1'b1;
              sa   = RE;
              sb   = RE;
              dst  = RE;
            end
          end
          4'd3:  begin want = 1'b1; sb = 4'd4; end
          4'd4:  begin want = 1'b1; sb = 4'd7; end
          4'd5:  begin want = 1'b1; sb = 4'd2; dst = RL; end
          4'd6:  begin want = 1'b1; sa = 4'd1; sb = 4'd2; end
          4'd7:  begin want = 1'b1; sb = 4'd0; end
          4'd9:  begin want = 1'b1; sb = 4'd6; end
          4'd10: begin want = 1'b1; sb = 4'd7; end
          4'd11: begin want = 1'b1; sb = 4'd5; end
          4'd12: want = (hc != half);
          4'd13: begin want = 1'b1; sb = RL; end
          default: want = 1'b0;
        endcase
      end
      default: want = 1'b0;
    endcase
  end

  assign fire = !want || (pend && mdone);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      done <= 1'b0;
      err  <= 1'b0;
      y    <= '0;
      pend <= 1'b0;
      mgo  <= 1'b0;
      ma   <= '0;
      mb   <= '0;
      p_r  <= '0;
      dbuf <= '0;
      lenq <= '0;
      cnt  <= '0;
      si   <= '0;
      hc   <= '0;
      pc   <= '0;
      sub  <= '0;
      ib   <= '0;
      for (int k = 0; k < NR; k++) rf[k] <= '0;
    end else begin
      done <= 1'b0;
      mgo  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            st   <= S_LOAD;
            p_r  <= modulus;
            lenq <= (len > CW'(MAXD)) ? CW'(MAXD) : len;
            dbuf <= '0;
            err  <= 1'b0;
            cnt  <= '0;
            si   <= '0;
            hc   <= '0;
            pc   <= '0;
            sub  <= '0;
            ib   <= '0;
            pend <= 1'b0;
            for (int k = 0; k < 8; k++) rf[k] <= W'(1);
            rf[RS] <= x;
          end
        end
        S_LOAD: begin
          if (cnt == lenq) begin
            st <= (half == '0) ? S_POST : S_STEP;
          end else if (dig_vld) begin
            if (dig_in == 2'b10) begin
              err  <= 1'b1;
              done <= 1'b1;
              y    <= '0;
              st   <= S_IDLE;
            end else begin
              dbuf[DIW'({cnt, 1'b0}) +: 2] <= dig_in;
              cnt <= cnt + CW'(1);
            end
          end
        end
        default: begin
          if (want && !pend) begin
            mgo  <= 1'b1;
            ma   <= rf[sa];
            mb   <= rf[sb];
            pend <= 1'b1;
          end else if (fire) begin
            if (want) begin
              rf[dst] <= macc;
              pend    <= 1'b0;
            end
            case (st)
              S_STEP: st <= S_SQ;
              S_SQ: begin
                si <= si + CW'(1);
                st <= (si + CW'(1) == half) ? S_POST : S_STEP;
              end
              default: begin
                case (pc)
                  4'd2, 4'd8: begin
                    case (sub)
                      2'd0: begin
                        rf[RE] <= rf[RT];
                        rf[RT] <= W'(1);
                        ib     <= '0;
                        sub    <= 2'd1;
                      end
                      2'd1: sub <= 2'd2;
                      default: begin
                        if (ib == WB'(W - 1)) begin
                          sub <= 2'd0;
                          pc  <= pc + 4'd1;
                        end else begin
                          ib  <= ib + WB'(1);
                          sub <= 2'd1;
                        end
                      end
                    endcase
                  end
                  4'd12: begin
                    if (hc == half) pc <= pc + 4'd1;
                    else            hc <= hc + CW'(1);
                  end
                  4'd14: begin
                    y    <= rf[RT];
                    done <= 1'b1;
                    st   <= S_IDLE;
                  end
                  default: pc <= pc + 4'd1;
                endcase
              end
            endcase
          end
        end
      endcase
    end
  end

  AST_MUL_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n) mdone |-> (macc < p_r)); // R8
  AST_MUL_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) mgo |-> !mbusy); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
  AST_Y_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(y)); // R6
  AST_BAD_DIGIT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && cnt != lenq && dig_vld && dig_in == 2'b10) |=> (done && err && y == '0)); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st == S_POST) |=> (st != S_LOAD)); // R7
  AST_EMPTY_SKIPS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && cnt == lenq && lenq == '0) |=> (st == S_POST)); // R4

endmodule

// File: tb/hx_expo_bench.sv
module hx_expo_bench;
  localparam int W = 16;
  localparam int MAXD = 32;
  localparam int CW = $clog2(MAXD + 1);
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] x = '0;
  logic [W-1:0] modulus = '0;
  logic [CW-1:0] len = '0;
  logic dig_vld = 1'b0;
  logic [1:0] dig_in = 2'b00;
  logic done, err;
  logic [W-1:0] y;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit got_done = 1'b0;
  logic [W-1:0] g_y;
  logic g_err;
  bit finished = 1'b0;

  hx_expo #(.W(W), .MAXD(MAXD)) u_hx_expo (
    .clk(clk), .rst_n(rst_n), .start(start), .x(x), .modulus(modulus), .len(len),
    .dig_vld(dig_vld), .dig_in(dig_in), .done(done), .err(err), .y(y));

  always #(CLK_P / 2) clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (done) begin
      got_done = 1'b1;
      g_y = y;
      g_err = err;
    end
    if (cycles > 190000 && !finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog: run exceeded cycle limit, actual %0d expected below 190000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  function automatic longint mpow(longint b, longint e, longint p);
    longint r = 1;
    b = b % p;
    while (e > 0) begin
      if (e[0]) r = (r * b) % p;
      b = (b * b) % p;
      e = e >>> 1;
    end
    return r;
  endfunction

  function automatic longint ref_exp(longint xx, longint pp, logic [63:0] dg, int n);
    longint e = 0;
    for (int j = 0; j < n; j++) begin
      if (dg[2*j +: 2] == 2'b01) e += (longint'(1) <<< j);
      else if (dg[2*j +: 2] == 2'b11) e -= (longint'(1) <<< j);
    end
    if (e < 0) return mpow(mpow(xx, pp - 2, pp), -e, pp);
    return mpow(xx, e, pp);
  endfunction

  task automatic check(string req, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] rdig();
    int r = $urandom % 3;
    return (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b11;
  endfunction

  task automatic run_job(input longint xx, input longint pp, input int n, input logic [63:0] dg,
                         input bit gaps, input bit restart);
    got_done = 1'b0;
    @(negedge clk);
    x = W'(xx);
    modulus = W'(pp);
    len = CW'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    x = W'(16'hA5A5);
    modulus = W'(16'h0003);
    len = CW'(3);
    for (int j = 0; j < n; j++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        dig_vld = 1'b0;
        dig_in = 2'b10;
        @(negedge clk);
        dig_in = 2'($urandom);
        @(negedge clk);
      end
      dig_vld = 1'b1;
      dig_in = dg[2*j +: 2];
      @(negedge clk);
      dig_vld = 1'b0;
      dig_in = 2'b10;
    end
    if (restart) begin
      repeat (5) @(negedge clk);
      x = W'(2);
      len = CW'(1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int k = 0; k < 20000 && !got_done; k++) @(negedge clk);
    if (!got_done) begin
      fails++;
      $display("FAIL timeout: no done, actual 0 expected 1");
    end
  endtask

  task automatic after_done_checks(string req);
    logic [W-1:0] held = g_y;
    @(negedge clk);
    check({req, " done width"}, done, 0);
    repeat (4) @(negedge clk);
    check({req, " y hold"}, y, held);
  endtask

  initial begin
    logic [63:0] dg;
    longint xx, pp;
    int n;
    longint primes [5] = '{65521, 32749, 8191, 251, 7};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 done", done, 0);
    check("R1 err", err, 0);
    check("R1 y", y, 0);
    rst_n = 1'b1;
    @(negedge clk);

    dg = '0;
    dg[1:0] = 2'b01; dg[3:2] = 2'b00; dg[5:4] = 2'b11; dg[7:6] = 2'b01;
    run_job(3, 7, 4, dg, 0, 0);
    check("R2 small", g_y, ref_exp(3, 7, dg, 4));
    check("R2 err", g_err, 0);
    after_done_checks("R6");

    run_job(1234, 65521, 0, '0, 0, 0);
    check("R4 empty", g_y, 1);

    dg = '0;
    for (int j = 0; j < 32; j++) dg[2*j +: 2] = 2'b11;
    run_job(65520, 65521, 32, dg, 0, 0);
    check("R8 x=p-1 all -1", g_y, ref_exp(65520, 65521, dg, 32));
    dg = '0;
    for (int j = 0; j < 32; j++) dg[2*j +: 2] = 2'b01;
    run_job(65519, 65521, 32, dg, 0, 0);
    check("R2 all +1", g_y, ref_exp(65519, 65521, dg, 32));

    dg = '0;
    dg[1:0] = 2'b11; dg[3:2] = 2'b01; dg[7:6] = 2'b11; dg[9:8] = 2'b01;
    run_job(17, 251, 5, dg, 0, 0);
    g_err = 1'b0;
    xx = g_y;
    check("R3 odd", xx, ref_exp(17, 251, dg, 5));
    run_job(17, 251, 6, dg, 0, 0);
    check("R3 padded equal", g_y, xx);

    dg = '0;
    dg[1:0] = 2'b01; dg[3:2] = 2'b10; dg[5:4] = 2'b01;
    run_job(5, 8191, 3, dg, 0, 0);
    check("R5 err", g_err, 1);
    check("R5 y", g_y, 0);
    check("R5 err held", err, 1);
    dg[3:2] = 2'b11;
    run_job(5, 8191, 3, dg, 0, 0);
    check("R5 err cleared", g_err, 0);
    check("R5 next valid", g_y, ref_exp(5, 8191, dg, 3));

    dg = '0;
    for (int j = 0; j < 20; j++) dg[2*j +: 2] = rdig();
    run_job(999, 32749, 20, dg, 1, 0);
    check("R9 gaps", g_y, ref_exp(999, 32749, dg, 20));

    dg = '0;
    for (int j = 0; j < 12; j++) dg[2*j +: 2] = rdig();
    run_job(77, 8191, 12, dg, 0, 1);
    check("R7 restart ignored", g_y, ref_exp(77, 8191, dg, 12));

    for (int t = 0; t < 18; t++) begin
      pp = primes[$urandom % 5];
      xx = 1 + ($urandom % (pp - 1));
      n = $urandom % (MAXD + 1);
      dg = '0;
      for (int j = 0; j < n; j++) dg[2*j +: 2] = rdig();
      run_job(xx, pp, n, dg, bit'($urandom % 2), 0);
      check("R2 random", g_y, ref_exp(xx, pp, dg, n));
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule